// File: doc/BRIEF.md
# In-Place Implication Logic Row

This block holds one row of binary cells and computes on them where they sit. Each accepted micro-operation does one of two things. It forces a chosen cell to 0, or it writes the implication of one or more source cells into a target cell, replacing the target's old value. A multi-source operation that follows a clear of the target gives a k-input NOR in two steps. Chains of these steps give NOT, copy (through a scratch cell) and any other Boolean function, because clearing and implication together are functionally complete.

Each cell has a small weakening counter. The counter models the way a retained zero degrades when an implication leaves it at 0 while some source reads 1. When any counter reaches its limit, the block raises a refresh request. Until a refresh operation arrives, it stalls every other operation. The refresh clears all counters and keeps all stored bits. The row contents are visible at a parallel read port.

Top module: `imply_row_engine`

## Requirements
- R1: After reset, every cell reads 0, every weakening counter is 0, `refresh_req_o` and `err_o` are low and `ready_o` is high.
- R2: Operation code 1 (clear) writes 0 into cell `dst_i` and clears that cell's counter. No other cell changes.
- R3: Operation code 2 (single implication) writes `(NOT row[src_i]) OR row[dst_i]` into cell `dst_i`. No other cell changes. Applied to a target holding 0, it yields NOT of the source. Four steps copy one cell to another through a scratch cell.
- R4: Operation code 3 (multi-source implication) writes `row[dst_i] OR NOT(OR of the cells selected by mask_i)` into cell `dst_i`. Preceded by a clear of the target, this gives the NOR of the selected cells.
- R5: A cell's counter increments when an implication leaves that cell at 0 while at least one selected source holds 1. It clears when an implication leaves the cell at 1. `refresh_req_o` is high while any counter is at its limit of 3.
- R6: While `refresh_req_o` is high, `ready_o` is low for every code except 4 (refresh). A stalled operation changes nothing. A refresh clears all counters, leaves the stored bits unchanged and drops `refresh_req_o`.
- R7: The following are rejected: an implication whose source set contains its own target (src equal to dst, or `mask_i` bit `dst_i` set), a multi-source implication with an empty mask, and codes 5 to 7. A rejected operation leaves cells and counters unchanged and pulses `err_o` high in the cycle after it is accepted.
- R8: An operation is accepted on a clock edge where `valid_i` and `ready_o` are both high, at most one per cycle. Code 0 is a legal no-op. With `valid_i` low the row does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation offered |
| ready_o | output | 1 | Operation can be taken this cycle |
| op_i | input | 3 | Operation code |
| src_i | input | 4 | Source cell index for single implication |
| dst_i | input | 4 | Target cell index |
| mask_i | input | 16 | Source set for multi-source implication |
| row_o | output | 16 | Stored cell bits |
| refresh_req_o | output | 1 | Some retained zero has reached the weakening limit |
| err_o | output | 1 | Previous accepted operation was rejected |

## Verification
The checks assume that no operation can add weakening to a cell whose counter is already at the limit. The stall on non-refresh codes is what guarantees this, so counter wrap is asserted as impossible rather than handled. The checks also assume that the operation fields stay steady within a cycle once `valid_i` is high. The bench changes inputs only on the falling edge, and it drives the limit case through the normal interface by weakening one cell three times and then offering a further implication while stalled.

// File: rtl/imply_row_pkg.sv
package imply_row_pkg;
  localparam int unsigned ROW_CELLS = 16;
  localparam int unsigned DRIFT_W   = 2;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_CLEAR   = 3'd1,
    OP_IMPLY   = 3'd2,
    OP_MIMPLY  = 3'd3,
    OP_REFRESH = 3'd4
  } row_op_e;
endpackage

// File: rtl/imply_row_cell.sv
module imply_row_cell #(
  parameter int unsigned DRIFT_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic val_i,
  input  logic drift_i,
  input  logic refresh_i,
  output logic bit_o,
  output logic at_limit_o
);
  localparam logic [DRIFT_W-1:0] LIMIT = {DRIFT_W{1'b1}};

  logic               bit_q;
  logic [DRIFT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b0;
      cnt_q <= '0;
    end else if (refresh_i) begin
      cnt_q <= '0;
    end else if (wr_i) begin
      bit_q <= val_i;
      cnt_q <= '0;
    end else if (drift_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign bit_o      = bit_q;
  assign at_limit_o = (cnt_q == LIMIT);

  // stall upstream must keep a saturated counter from being weakened again
  a_r5_drift_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LIMIT) |-> !drift_i);

  a_r6_refresh_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh_i |=> (cnt_q == '0) && $stable(bit_q));
endmodule

// File: rtl/imply_row_decode.sv
module imply_row_decode
  import imply_row_pkg::*;
#(
  parameter int unsigned N     = 16,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [N-1:0]     mask_i,
  input  logic [N-1:0]     row_i,
  output logic             legal_o,
  output logic             refresh_o,
  output logic [N-1:0]     wr_o,
  output logic             val_o,
  output logic [N-1:0]     drift_o
);
  logic [N-1:0] tgt, src_set;
  logic         src_hit, result;

  always_comb begin
    tgt     = N'(1) << dst_i;
    src_set = (row_op_e'(op_i) == OP_IMPLY) ? (N'(1) << src_i) : mask_i;
    src_hit = |(row_i & src_set);
    result  = row_i[dst_i] | ~src_hit;

    legal_o   = 1'b0;
    refresh_o = 1'b0;
    wr_o      = '0;
    val_o     = 1'b0;
    drift_o   = '0;
    case (row_op_e'(op_i))
      OP_NOP:     legal_o = 1'b1;
      OP_REFRESH: begin
        legal_o   = 1'b1;
        refresh_o = 1'b1;
      end
      OP_CLEAR: begin
        legal_o = 1'b1;
        wr_o    = tgt;
      end
      OP_IMPLY, OP_MIMPLY: begin
        legal_o = ((src_set & tgt) == '0) && (src_set != '0);
        if (legal_o) begin
          if (result) begin
            wr_o  = tgt;
            val_o = 1'b1;
          end else begin
            drift_o = tgt; // retained zero weakened by a source at 1
          end
        end
      end
      default: legal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/imply_row_engine.sv
module imply_row_engine
  import imply_row_pkg::*;
#(
  parameter int unsigned N       = ROW_CELLS,
  parameter int unsigned DRIFT_W = imply_row_pkg::DRIFT_W,
  localparam int unsigned IDX_W  = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  output logic             ready_o,
  input  logic [2:0]       op_i,
  input  logic [IDX_W-1:0] src_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [N-1:0]     mask_i,
  output logic [N-1:0]     row_o,
  output logic             refresh_req_o,
  output logic             err_o
);
  logic         acc, legal, refresh;
  logic         val;
  logic [N-1:0] wr_vec, drift_vec, at_limit;
  logic         err_q;

  imply_row_decode #(.N(N), .IDX_W(IDX_W)) u_dec (
    .op_i     (op_i),
    .src_i    (src_i),
    .dst_i    (dst_i),
    .mask_i   (mask_i),
    .row_i    (row_o),
    .legal_o  (legal),
    .refresh_o(refresh),
    .wr_o     (wr_vec),
    .val_o    (val),
    .drift_o  (drift_vec)
  );

  assign refresh_req_o = |at_limit;
  assign ready_o       = !refresh_req_o || (row_op_e'(op_i) == OP_REFRESH);
  assign acc           = valid_i && ready_o;

  for (genvar g = 0; g < N; g++) begin : g_cell
    imply_row_cell #(.DRIFT_W(DRIFT_W)) u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (acc && wr_vec[g]),
      .val_i     (val),
      .drift_i   (acc && drift_vec[g]),
      .refresh_i (acc && refresh),
      .bit_o     (row_o[g]),
      .at_limit_o(at_limit[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= acc && !legal;
  end
  assign err_o = err_q;

  a_r2_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && row_op_e'(op_i) == OP_CLEAR) |=> !row_o[$past(dst_i)]);

  a_r3_imply_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && legal && row_op_e'(op_i) == OP_IMPLY) |=>
      row_o[$past(dst_i)] == (!$past(row_o[src_i]) || $past(row_o[dst_i])));

  a_r6_refresh_drops_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && row_op_e'(op_i) == OP_REFRESH) |=> !refresh_req_o && $stable(row_o));

  a_r7_reject_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !legal) |=> err_o && $stable(row_o));

  a_r8_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(row_o));
endmodule

// File: tb/imply_row_engine_tb_top.sv
module imply_row_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic        ready;
  logic [2:0]  op = '0;
  logic [3:0]  src = '0, dst = '0;
  logic [15:0] mask = '0;
  logic [15:0] row;
  logic        req, err;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  imply_row_engine dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .ready_o(ready),
    .op_i(op), .src_i(src), .dst_i(dst), .mask_i(mask),
    .row_o(row), .refresh_req_o(req), .err_o(err)
  );

  // {op, src, dst, mask, exp_row, exp_err, exp_req}
  localparam int NV = 17;
  localparam logic [44:0] VEC [NV] = '{
    {3'd2, 4'd0, 4'd1,  16'h0000, 16'h0002, 1'b0, 1'b0}, // R3 0->0 sets
    {3'd2, 4'd2, 4'd3,  16'h0000, 16'h000A, 1'b0, 1'b0}, // R3
    {3'd2, 4'd1, 4'd4,  16'h0000, 16'h000A, 1'b0, 1'b0}, // R5 drift c4=1
    {3'd2, 4'd0, 4'd3,  16'h0000, 16'h000A, 1'b0, 1'b0}, // R3 reinforce
    {3'd1, 4'd0, 4'd3,  16'h0000, 16'h0002, 1'b0, 1'b0}, // R2
    {3'd1, 4'd0, 4'd5,  16'h0000, 16'h0002, 1'b0, 1'b0}, // R2
    {3'd2, 4'd1, 4'd5,  16'h0000, 16'h0002, 1'b0, 1'b0}, // R3 NOT 1 = 0
    {3'd2, 4'd0, 4'd6,  16'h0000, 16'h0042, 1'b0, 1'b0}, // R3 NOT 0 = 1
    {3'd3, 4'd0, 4'd7,  16'h0005, 16'h00C2, 1'b0, 1'b0}, // R4 NOR(0,0)
    {3'd3, 4'd0, 4'd8,  16'h0006, 16'h00C2, 1'b0, 1'b0}, // R4 NOR(1,0)
    {3'd2, 4'd9, 4'd9,  16'h0000, 16'h00C2, 1'b1, 1'b0}, // R7 src==dst
    {3'd3, 4'd0, 4'd9,  16'h0201, 16'h00C2, 1'b1, 1'b0}, // R7 mask has dst
    {3'd3, 4'd0, 4'd10, 16'h0000, 16'h00C2, 1'b1, 1'b0}, // R7 empty mask
    {3'd7, 4'd0, 4'd0,  16'h0000, 16'h00C2, 1'b1, 1'b0}, // R7 bad code
    {3'd0, 4'd0, 4'd0,  16'h0000, 16'h00C2, 1'b0, 1'b0}, // R8 no-op
    {3'd2, 4'd1, 4'd4,  16'h0000, 16'h00C2, 1'b0, 1'b0}, // R5 c4=2
    {3'd2, 4'd1, 4'd4,  16'h0000, 16'h00C2, 1'b0, 1'b1}  // R5 c4=3 -> req
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] o, input logic [3:0] s, input logic [3:0] d,
                       input logic [15:0] m);
    @(negedge clk);
    op = o; src = s; dst = d; mask = m; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 row", 32'(row), 32'h0);
    chk("R1 req/err/ready", {29'd0, req, err, ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [44:0] v;
      v = VEC[i];
      issue(v[44:42], v[41:38], v[37:34], v[33:18]);
      chk("R2-R8 table row", 32'(row), 32'(v[17:2]));
      chk("R5/R7 table err/req", {30'd0, err, req}, {30'd0, v[1], v[0]});
    end

    // R6: stalled while refresh requested
    @(negedge clk);
    op = 3'd2; src = 4'd0; dst = 4'd10; mask = '0; valid = 1'b1;
    #1 chk("R6 ready low on stall", 32'(ready), 32'h0);
    @(negedge clk);
    valid = 1'b0;
    chk("R6 stalled op no change", 32'(row), 32'h00C2);
    op = 3'd4;
    #1 chk("R6 ready for refresh", 32'(ready), 32'h1);
    issue(3'd4, 4'd0, 4'd0, 16'h0);
    chk("R6 refresh keeps bits", 32'(row), 32'h00C2);
    chk("R6 refresh drops req", 32'(req), 32'h0);
    issue(3'd2, 4'd1, 4'd4, 16'h0);
    issue(3'd2, 4'd1, 4'd4, 16'h0);
    chk("R6 counters cleared", 32'(req), 32'h0);

    // R2: clear resets a counter
    issue(3'd2, 4'd1, 4'd8, 16'h0);
    issue(3'd1, 4'd0, 4'd8, 16'h0);
    issue(3'd2, 4'd1, 4'd8, 16'h0);
    issue(3'd2, 4'd1, 4'd8, 16'h0);
    chk("R2 clear resets counter", 32'(req), 32'h0);

    // R5: switch to 1 resets counter
    issue(3'd2, 4'd1, 4'd9, 16'h0);
    issue(3'd2, 4'd1, 4'd9, 16'h0);
    issue(3'd2, 4'd0, 4'd9, 16'h0);
    chk("R5 switch sets bit", 32'(row[9]), 32'h1);
    chk("R5 switch no req", 32'(req), 32'h0);

    // R8: valid low ignored
    @(negedge clk);
    op = 3'd1; dst = 4'd6; valid = 1'b0;
    @(negedge clk);
    chk("R8 idle no change", 32'(row), 32'h02C2);

    // R3: copy cell 6 to 11 via scratch 12
    issue(3'd1, 4'd0, 4'd11, 16'h0);
    issue(3'd1, 4'd0, 4'd12, 16'h0);
    issue(3'd2, 4'd6, 4'd12, 16'h0);
    issue(3'd2, 4'd12, 4'd11, 16'h0);
    chk("R3 copy result", 32'(row), 32'h0AC2);

    // R4: NOR of cells 11,12 into 13 and of 12,14 into 14? (14 is target) -> use 15
    issue(3'd1, 4'd0, 4'd13, 16'h0);
    issue(3'd3, 4'd0, 4'd13, 16'h1800);
    issue(3'd1, 4'd0, 4'd15, 16'h0);
    issue(3'd3, 4'd0, 4'd15, 16'h5000);
    chk("R4 NOR results", 32'(row), 32'h8AC2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule